// File: doc/BRIEF.md
# Tape Serial Byte Datapath

This block sits between the tape head's bit stream and the host's 8-bit data register inside a cassette tape controller. When reading, it hunts for a single 1 sync bit, then assembles bytes most significant bit first and hands each finished byte to the data register with a ready pulse. When writing, it answers each bit request from the head logic. It first sends a preamble of zero bits one byte long, then the bits of the loaded word MSB first, and it reloads from the data register at every byte boundary.

For an in-place rewrite, the block first listens in read mode. The first bit that arrives, of either value, makes it switch the head to write and start the preamble. The block does not own the command state. It reads the state from the controller's sequencer, and it returns one-cycle requests that tell the sequencer which state to enter next. Every response appears one clock after the strobe that caused it.

Top module: `tape_byte_path`

## Requirements
- R1: After reset the data register reads 0 and all response outputs (write bit, write-bit valid, ready pulse, state request, requested state, head-write request) are 0.
- R2: The command state input is coded 0 idle, 1 read sync hunt, 2 read shifting, 3 rewrite hunt, 4 write preamble, 5 write shifting; codes 6 and 7 are unused. A strobe that the current state does not handle (any strobe in idle or an unused code, a write request in the read or rewrite-hunt states, a read strobe in the write states) produces no response and changes nothing.
- R3: In the read sync hunt, a received 0 is ignored; a received 1 requests state 2 and starts a fresh, empty byte.
- R4: In read shifting, received bits fill the byte MSB first: the first bit after sync is bit 7 of the byte.
- R5: The eighth received bit of a byte writes the assembled byte into the data register and pulses ready; the following bit starts a new, empty byte.
- R6: In rewrite hunt, any received bit requests state 4, pulses the head-write request, pulses ready and loads the data register's current value as the word to write.
- R7: In write preamble, each write request returns bit 0; the eighth request also requests state 5.
- R8: In write shifting, write requests return the loaded word's bits MSB first; the request that returns bit 0 also loads the data register's current value as the next word and pulses ready, without a state request.
- R9: A host write takes effect on the data register one clock later; when a completed read byte and a host write land in the same cycle, the read byte is kept.
- R10: All responses appear one clock after their strobe; write-bit valid and ready are one-cycle pulses, the requested state output is 0 whenever no request is made, and the write bit holds its last value between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_state_i | input | 3 | Command state from the sequencer (codes in R2) |
| rd_stb_i | input | 1 | One-cycle strobe: a bit was read from tape |
| rd_bit_i | input | 1 | Value of the read bit, valid with rd_stb_i |
| wr_req_i | input | 1 | One-cycle request for the next bit to write |
| host_we_i | input | 1 | Host write strobe for the data register |
| host_wdata_i | input | 8 | Host write data |
| wr_bit_o | output | 1 | Bit to write, held between requests |
| wr_bit_vld_o | output | 1 | Pulse: wr_bit_o answers a request |
| data_o | output | 8 | Data register read value |
| ready_set_o | output | 1 | Pulse: set the ready status flag |
| seq_req_vld_o | output | 1 | Pulse: sequencer should change state |
| seq_req_state_o | output | 3 | Requested state, 0 when no request |
| head_wr_req_o | output | 1 | Pulse: switch head operation to write |

## Verification
The bench attacks the byte boundaries. These are the wrap after the eighth read bit, the eighth preamble zero, and the reload at the end of a written word. An off-by-one index there would produce a seven- or nine-bit byte, a preamble of the wrong length, or a missing ready pulse. It sends zeros before the sync bit, and sends a 0 as the first bit in rewrite hunt. A design that treats zeros as sync would lock onto the wrong position, and one that waits for a 1 would never start rewriting. It lands a host write on the same cycle as a finished read byte, and writes the next byte during the preamble. Reversed priority would lose read data, and an early reload would write the wrong word. Strobes in idle, in unused codes and in the wrong direction must leave every output quiet.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_HUNT  = 3'd1,
        ST_RD_SHIFT = 3'd2,
        ST_RW_HUNT  = 3'd3,
        ST_WR_PRE   = 3'd4,
        ST_WR_SHIFT = 3'd5
    } seq_state_e;

    typedef enum logic [2:0] {
        SH_HOLD,
        SH_CLEAR,
        SH_RX,
        SH_TX,
        SH_LOAD
    } sh_op_e;

endpackage

// File: rtl/tbp_shifter.sv
module tbp_shifter
    import tbp_pkg::*;
#(
    parameter int unsigned WORD_W = 8,
    localparam int unsigned IDX_W = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  sh_op_e            op_i,
    input  logic              bit_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              idx_zero_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              tx_bit_o
);

    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [IDX_W-1:0]  idx;
    } sh_t;

    sh_t sh_d, sh_q;

    assign idx_zero_o = (sh_q.idx == '0);
    assign rx_word_o  = sh_q.sr | ({{(WORD_W-1){1'b0}}, bit_i} << sh_q.idx);
    assign tx_bit_o   = sh_q.sr[sh_q.idx];

    always_comb begin
        sh_d = sh_q;
        case (op_i)
            SH_CLEAR: begin
                sh_d.sr  = '0;
                sh_d.idx = IDX_TOP;
            end
            SH_RX: begin
                if (idx_zero_o) begin
                    sh_d.sr  = '0;
                    sh_d.idx = IDX_TOP;
                end else begin
                    sh_d.sr  = rx_word_o;
                    sh_d.idx = sh_q.idx - 1'b1;
                end
            end
            SH_TX: begin
                sh_d.idx = idx_zero_o ? IDX_TOP : sh_q.idx - 1'b1;
            end
            SH_LOAD: begin
                sh_d.sr  = word_i;
                sh_d.idx = IDX_TOP;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '{sr: '0, idx: IDX_TOP};
        end else begin
            sh_q <= sh_d;
        end
    end

    // R5: the last bit of a byte leaves an empty byte at the top index
    assert_rx_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == SH_RX && idx_zero_o) |=> (sh_q.idx == IDX_TOP && sh_q.sr == '0))
        else $error("rx wrap");

    // R8: a write shift that does not wrap steps the index down by one
    assert_tx_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == SH_TX && !idx_zero_o) |=> (sh_q.idx == $past(sh_q.idx) - 1'b1))
        else $error("tx step");

endmodule

// File: rtl/tbp_datareg.sv
module tbp_datareg #(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_we_i,
    input  logic [WORD_W-1:0] host_data_i,
    input  logic              cap_we_i,
    input  logic [WORD_W-1:0] cap_data_i,
    output logic [WORD_W-1:0] data_o
);

    logic [WORD_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (cap_we_i) begin
            data_d = cap_data_i;
        end else if (host_we_i) begin
            data_d = host_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_o = data_q;

    // R9: a captured read byte beats a simultaneous host write
    assert_cap_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_we_i && host_we_i) |=> (data_o == $past(cap_data_i)))
        else $error("capture priority");

endmodule

// File: rtl/tape_byte_path.sv
module tape_byte_path
    import tbp_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        cmd_state_i,
    input  logic              rd_stb_i,
    input  logic              rd_bit_i,
    input  logic              wr_req_i,
    input  logic              host_we_i,
    input  logic [WORD_W-1:0] host_wdata_i,
    output logic              wr_bit_o,
    output logic              wr_bit_vld_o,
    output logic [WORD_W-1:0] data_o,
    output logic              ready_set_o,
    output logic              seq_req_vld_o,
    output logic [2:0]        seq_req_state_o,
    output logic              head_wr_req_o
);

    typedef struct packed {
        logic       wbit;
        logic       wvld;
        logic       ready;
        logic       rvld;
        logic [2:0] rstate;
        logic       headwr;
    } rsp_t;

    rsp_t              rsp_d, rsp_q;
    seq_state_e        st;
    sh_op_e            sh_op;
    logic              cap_we;
    logic              idx_zero;
    logic              tx_bit;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] data_q;

    assign st = seq_state_e'(cmd_state_i);

    always_comb begin
        rsp_d      = '0;
        rsp_d.wbit = rsp_q.wbit;
        sh_op      = SH_HOLD;
        cap_we     = 1'b0;
        case (st)
            ST_RD_HUNT: begin
                if (rd_stb_i && rd_bit_i) begin
                    sh_op        = SH_CLEAR;
                    rsp_d.rvld   = 1'b1;
                    rsp_d.rstate = ST_RD_SHIFT;
                end
            end
            ST_RD_SHIFT: begin
                if (rd_stb_i) begin
                    sh_op = SH_RX;
                    if (idx_zero) begin
                        cap_we      = 1'b1;
                        rsp_d.ready = 1'b1;
                    end
                end
            end
            ST_RW_HUNT: begin
                if (rd_stb_i) begin
                    sh_op        = SH_LOAD;
                    rsp_d.ready  = 1'b1;
                    rsp_d.rvld   = 1'b1;
                    rsp_d.rstate = ST_WR_PRE;
                    rsp_d.headwr = 1'b1;
                end
            end
            ST_WR_PRE: begin
                if (wr_req_i) begin
                    sh_op      = SH_TX;
                    rsp_d.wbit = 1'b0;
                    rsp_d.wvld = 1'b1;
                    if (idx_zero) begin
                        rsp_d.rvld   = 1'b1;
                        rsp_d.rstate = ST_WR_SHIFT;
                    end
                end
            end
            ST_WR_SHIFT: begin
                if (wr_req_i) begin
                    rsp_d.wbit = tx_bit;
                    rsp_d.wvld = 1'b1;
                    if (idx_zero) begin
                        sh_op       = SH_LOAD;
                        rsp_d.ready = 1'b1;
                    end else begin
                        sh_op = SH_TX;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    tbp_shifter #(.WORD_W(WORD_W)) u_shifter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .op_i       (sh_op),
        .bit_i      (rd_bit_i),
        .word_i     (data_q),
        .idx_zero_o (idx_zero),
        .rx_word_o  (rx_word),
        .tx_bit_o   (tx_bit)
    );

    tbp_datareg #(.WORD_W(WORD_W)) u_datareg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .host_we_i   (host_we_i),
        .host_data_i (host_wdata_i),
        .cap_we_i    (cap_we),
        .cap_data_i  (rx_word),
        .data_o      (data_q)
    );

    assign data_o          = data_q;
    assign wr_bit_o        = rsp_q.wbit;
    assign wr_bit_vld_o    = rsp_q.wvld;
    assign ready_set_o     = rsp_q.ready;
    assign seq_req_vld_o   = rsp_q.rvld;
    assign seq_req_state_o = rsp_q.rstate;
    assign head_wr_req_o   = rsp_q.headwr;

    // R2: idle state never answers a strobe
    assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_state_i == 3'd0) |=>
            !(ready_set_o || seq_req_vld_o || wr_bit_vld_o || head_wr_req_o))
        else $error("idle response");

    // R3: zeros during sync hunt are ignored
    assert_hunt_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_state_i == 3'd1 && rd_stb_i && !rd_bit_i) |=>
            (!seq_req_vld_o && !ready_set_o))
        else $error("zero taken as sync");

    // R6: any bit in rewrite hunt starts the preamble with the head writing
    assert_rewrite_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_state_i == 3'd3 && rd_stb_i) |=>
            (seq_req_vld_o && seq_req_state_o == 3'd4 && head_wr_req_o && ready_set_o))
        else $error("rewrite switch");

    // R7: preamble bits are zero
    assert_preamble_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_state_i == 3'd4 && wr_req_i) |=> (wr_bit_vld_o && !wr_bit_o))
        else $error("preamble bit");

endmodule

// File: tb/tape_byte_path_test.sv
`timescale 1ns/1ps
module tape_byte_path_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_state = 3'd0;
    logic       rd_stb = 1'b0;
    logic       rd_bit = 1'b0;
    logic       wr_req = 1'b0;
    logic       host_we = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       wr_bit, wr_bit_vld, ready_set, seq_req_vld, head_wr_req;
    logic [7:0] data_out;
    logic [2:0] seq_req_state;

    int total = 0;
    int bad = 0;

    // reference model state
    logic [7:0] m_data = 8'h00;
    logic       m_wbit = 1'b0;
    bit         rxq[$];
    bit         txq[$];
    int         pre_cnt = 0;

    always #2.5 clk = ~clk;

    tape_byte_path uut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .cmd_state_i     (cmd_state),
        .rd_stb_i        (rd_stb),
        .rd_bit_i        (rd_bit),
        .wr_req_i        (wr_req),
        .host_we_i       (host_we),
        .host_wdata_i    (host_wdata),
        .wr_bit_o        (wr_bit),
        .wr_bit_vld_o    (wr_bit_vld),
        .data_o          (data_out),
        .ready_set_o     (ready_set),
        .seq_req_vld_o   (seq_req_vld),
        .seq_req_state_o (seq_req_state),
        .head_wr_req_o   (head_wr_req)
    );

    function automatic void load_tx(input logic [7:0] w);
        txq.delete();
        for (int i = 7; i >= 0; i--) txq.push_back(w[i]);
    endfunction

    task automatic cyc(input logic rs, input logic rb, input logic wq,
                       input logic hw, input logic [7:0] hd, input string tag);
        logic       e_wvld = 1'b0, e_ready = 1'b0, e_rvld = 1'b0, e_head = 1'b0;
        logic [2:0] e_rst = 3'd0;
        logic       cap = 1'b0;
        logic [7:0] cap_w = 8'h00;
        logic [15:0] got, exp;
        rd_stb = rs; rd_bit = rb; wr_req = wq; host_we = hw; host_wdata = hd;
        case (cmd_state)
            3'd1: if (rs && rb) begin rxq.delete(); e_rvld = 1'b1; e_rst = 3'd2; end
            3'd2: if (rs) begin
                rxq.push_back(rb);
                if (rxq.size() == 8) begin
                    for (int i = 0; i < 8; i++) cap_w[7-i] = rxq[i];
                    cap = 1'b1; e_ready = 1'b1; rxq.delete();
                end
            end
            3'd3: if (rs) begin
                load_tx(m_data); pre_cnt = 0;
                e_ready = 1'b1; e_rvld = 1'b1; e_rst = 3'd4; e_head = 1'b1;
            end
            3'd4: if (wq) begin
                m_wbit = 1'b0; e_wvld = 1'b1; pre_cnt++;
                if (pre_cnt == 8) begin e_rvld = 1'b1; e_rst = 3'd5; pre_cnt = 0; end
            end
            3'd5: if (wq) begin
                m_wbit = txq.pop_front(); e_wvld = 1'b1;
                if (txq.size() == 0) begin load_tx(m_data); e_ready = 1'b1; end
            end
            default: ;
        endcase
        if (cap) m_data = cap_w;
        else if (hw) m_data = hd;
        @(posedge clk);
        @(negedge clk);
        got = {wr_bit, wr_bit_vld, ready_set, seq_req_vld, seq_req_state, head_wr_req, data_out};
        exp = {m_wbit, e_wvld, e_ready, e_rvld, e_rst, e_head, m_data};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: {wbit,wvld,ready,req,state,head,data} actual=%h expected=%h",
                     tag, got, exp);
        end
        rd_stb = 1'b0; wr_req = 1'b0; host_we = 1'b0;
        if (e_rvld) cmd_state = e_rst;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, tag);
    endtask

    task automatic rd_byte(input logic [7:0] b, input string tag);
        for (int i = 7; i >= 0; i--) begin
            cyc(1'b1, b[i], 1'b0, 1'b0, 8'h00, tag);
            idle(1, tag);
        end
    endtask

    task automatic wr_n(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if ({wr_bit, wr_bit_vld, ready_set, seq_req_vld, seq_req_state, head_wr_req, data_out} !== 16'h0) begin
            bad++;
            $display("FAIL R1: reset outputs actual=%h expected=0000",
                {wr_bit, wr_bit_vld, ready_set, seq_req_vld, seq_req_state, head_wr_req, data_out});
        end
        rst_n = 1'b1;
        idle(2, "R1");

        // strobes in idle are ignored; host write lands a cycle later
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R2");
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, "R9");
        idle(1, "R10");

        // read: zeros before sync, then sync, then two bytes
        cmd_state = 3'd1;
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R3");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R3");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R2");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R3");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R2");
        rd_byte(8'hC6, "R4");
        rd_byte(8'h3B, "R5");
        // last bit of a byte collides with a host write
        for (int i = 7; i >= 1; i--) cyc(1'b1, i[0], 1'b0, 1'b0, 8'h00, "R4");
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, "R9");
        rd_byte(8'h01, "R5");

        // rewrite: first bit of value 0 starts the preamble
        cmd_state = 3'd0;
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h96, "R9");
        cmd_state = 3'd3;
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R2");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R6");
        wr_n(3, "R7");
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, "R9");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R2");
        wr_n(5, "R7");
        wr_n(4, "R8");
        idle(2, "R10");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R2");
        wr_n(4, "R8");
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h0F, "R9");
        wr_n(8, "R8");
        wr_n(8, "R8");

        // unused state codes
        cmd_state = 3'd6;
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R2");
        cmd_state = 3'd7;
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R2");
        idle(2, "R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule